// File: doc/BRIEF.md
# Flash Password Protection Controller

This block is the command front end for the protection password of a flash device and for the two one-time bits that choose between password protection and persistent protection. A host writes to it through a 16-bit bus made of an address, data and a write strobe that is valid for one clock. Each write is taken on the clock edge where the strobe is high. The host reads through the same address lines, and the read data is combinational from the controller state and the address. Every command begins with two unlock writes and then a command write. The command code sits in the low byte of the data, and the upper byte is ignored.

The 64-bit password is split into four 16-bit portions, and each portion is programmed with its own command. Programming can only clear bits. The verify command reads a portion back until the password lock bit is set, and after that it reads as all ones. Each lock bit is programmed by four writes in a row: the entry command, a start code, a timed wait and a verify code. The verify result then appears on bit 0 of the read data. The two lock bits exclude each other, and only a power-on reset clears them. The program wait is a down-counter whose length in clock cycles is a parameter.

Top module: `pwp_ctrl`

## Requirements
- R1: After reset the password is all ones, both lock bits are clear, busy_o is 0 and rdata_o reads 0000h.
- R2: A command starts with a write of AAh to address 555h, then a write of 55h to address 2AAh, then the command code written to address 555h. A wrong address or data at any of these steps returns the block to idle and changes no stored state.
- R3: Command 38h is followed by one data write. Address bits [1:0] of that write select the portion: 0 selects password bits 15:0 and 3 selects bits 63:48. The portion becomes the AND of its old value and the written data.
- R4: If the written data has a 1 where the portion already holds a 0, that cell stays 0 and the status word reads 00A0h (error bit 5 set) instead of 0080h.
- R5: Each program step and each lock program holds busy_o high for exactly PROG_CYC cycles, and rdata_o reads 0000h during that time. After a password program, rdata_o reads the status word (bit 7 set) until a write of F0h.
- R6: Command C8h enters verify. Reads return the portion selected by addr_i[1:0], or FFFFh while the password lock is set. A write of F0h or 90h returns to idle.
- R7: Command 60h selects the password lock and command 64h selects the persistent lock. The next write must be 68h, which starts the timed program. After the timed program the next write must be 48h. After that, rdata_o[0] shows the selected bit and the other read bits are 0. Any other code at either step returns to idle.
- R8: A lock bit never clears except by reset. A lock bit is never set while the other lock bit is set, and a blocked attempt verifies as 0.
- R9: While the password lock is set, a password program leaves the password unchanged and reports status 00A0h.
- R10: Writes made while busy_o is high are ignored.
- R11: An unknown command code after a valid unlock returns the block to idle.
- R12: In lock verify, a write of 68h runs the timed program again, and a write of F0h or 90h returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| we_i | input | 1 | Write strobe, one write per high cycle |
| addr_i | input | ADDR_W | Write and read address |
| wdata_i | input | DW | Write data, command code in the low byte |
| rdata_o | output | DW | Read data or status for the current address |
| busy_o | output | 1 | Timed program in progress |

## Verification
The hardest paths to reach are the refused lock attempts. One lock bit must already be set before the other can be attempted, and since the bits never clear, the two success paths cannot both be tested in one pass. The stimulus therefore sets the persistent lock first and then attempts the password lock. It then applies a power-on reset, sets the password lock, attempts the persistent lock, and checks that verify is blanked and that password programming is refused. Writes that would clear password bits are also issued during the busy window, and the password read back afterwards must be unchanged.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_UL1, S_UL2, S_PW_DATA, S_PW_BUSY, S_PW_STAT,
    S_VERIFY, S_LK_CMD, S_LK_BUSY, S_LK_WAIT, S_LK_VER
  } state_e;

  localparam logic [7:0] C_UL1     = 8'hAA;
  localparam logic [7:0] C_UL2     = 8'h55;
  localparam logic [7:0] C_PW_PROG = 8'h38;
  localparam logic [7:0] C_PW_VER  = 8'hC8;
  localparam logic [7:0] C_LK_PW   = 8'h60;
  localparam logic [7:0] C_LK_PS   = 8'h64;
  localparam logic [7:0] C_LK_GO   = 8'h68;
  localparam logic [7:0] C_LK_CHK  = 8'h48;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_EXIT    = 8'h90;
  localparam logic [11:0] A_UL1    = 12'h555;
  localparam logic [11:0] A_UL2    = 12'h2AA;
endpackage

// File: rtl/pwp_timer.sv
module pwp_timer #(
  parameter int CYC = 18750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= CW'(CYC - 1);
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwp_store.sv
module pwp_store #(
  parameter int DW    = 16,
  parameter int PARTS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(PARTS)-1:0] sel_i,
  input  logic [DW-1:0]            data_i,
  output logic [DW-1:0]            part_o,
  output logic                     raise_o,
  output logic [DW*PARTS-1:0]      pwd_o
);
  logic [DW-1:0] cell_q [PARTS];

  for (genvar g = 0; g < PARTS; g++) begin : g_part
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                               cell_q[g] <= '1;
      else if (we_i && sel_i == g[$clog2(PARTS)-1:0]) cell_q[g] <= cell_q[g] & data_i;
    assign pwd_o[g*DW +: DW] = cell_q[g];
  end

  assign part_o  = cell_q[sel_i];
  assign raise_o = |(data_i & ~cell_q[sel_i]);
endmodule

// File: rtl/pwp_locks.sv
module pwp_locks (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_pw_i,
  input  logic set_ps_i,
  output logic pw_o,
  output logic ps_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pw_o <= 1'b0;
      ps_o <= 1'b0;
    end else begin
      if (set_pw_i && !ps_o) pw_o <= 1'b1;
      if (set_ps_i && !pw_o) ps_o <= 1'b1;
    end
endmodule

// File: rtl/pwp_ctrl.sv
module pwp_ctrl
  import pwp_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DW       = 16,
  parameter int PROG_CYC = 18750
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              busy_o
);
  localparam int PARTS = 4;
  localparam int SW    = $clog2(PARTS);

  state_e state_q, state_d;
  logic err_q, err_d, sel_q, sel_d;
  logic pw_we, tmr_load, tmr_done, set_pw, set_ps;
  logic pw_lock, ps_lock, raise;
  logic [DW-1:0] part;
  logic [DW*PARTS-1:0] pwd;
  logic [7:0] code;
  logic at_ul1, at_ul2, leave;

  assign code   = wdata_i[7:0];
  assign at_ul1 = (addr_i == ADDR_W'(A_UL1));
  assign at_ul2 = (addr_i == ADDR_W'(A_UL2));
  assign leave  = (code == C_RESET) || (code == C_EXIT);
  assign busy_o = (state_q == S_PW_BUSY) || (state_q == S_LK_BUSY);

  pwp_timer #(.CYC(PROG_CYC)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .run_i(busy_o), .done_o(tmr_done)
  );

  pwp_store #(.DW(DW), .PARTS(PARTS)) u_store (
    .clk_i, .rst_ni, .we_i(pw_we), .sel_i(addr_i[SW-1:0]), .data_i(wdata_i),
    .part_o(part), .raise_o(raise), .pwd_o(pwd)
  );

  pwp_locks u_locks (
    .clk_i, .rst_ni, .set_pw_i(set_pw), .set_ps_i(set_ps),
    .pw_o(pw_lock), .ps_o(ps_lock)
  );

  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    sel_d    = sel_q;
    pw_we    = 1'b0;
    tmr_load = 1'b0;
    set_pw   = 1'b0;
    set_ps   = 1'b0;
    unique case (state_q)
      S_IDLE:    if (we_i && at_ul1 && code == C_UL1) state_d = S_UL1;
      S_UL1:     if (we_i) state_d = (at_ul2 && code == C_UL2) ? S_UL2 : S_IDLE;
      S_UL2: if (we_i) begin
        state_d = S_IDLE;
        if (at_ul1) begin
          case (code)
            C_PW_PROG: state_d = S_PW_DATA;
            C_PW_VER:  state_d = S_VERIFY;
            C_LK_PW:   begin state_d = S_LK_CMD; sel_d = 1'b0; end
            C_LK_PS:   begin state_d = S_LK_CMD; sel_d = 1'b1; end
            default:   state_d = S_IDLE;
          endcase
        end
      end
      S_PW_DATA: if (we_i) begin
        pw_we    = !pw_lock;
        err_d    = pw_lock || raise;
        tmr_load = 1'b1;
        state_d  = S_PW_BUSY;
      end
      S_PW_BUSY: if (tmr_done) state_d = S_PW_STAT;
      S_PW_STAT: if (we_i && code == C_RESET) state_d = S_IDLE;
      S_VERIFY:  if (we_i && leave) state_d = S_IDLE;
      S_LK_CMD: if (we_i) begin
        tmr_load = (code == C_LK_GO);
        state_d  = (code == C_LK_GO) ? S_LK_BUSY : S_IDLE;
      end
      S_LK_BUSY: if (tmr_done) begin
        set_pw  = !sel_q;
        set_ps  = sel_q;
        state_d = S_LK_WAIT;
      end
      S_LK_WAIT: if (we_i) state_d = (code == C_LK_CHK) ? S_LK_VER : S_IDLE;
      S_LK_VER: if (we_i) begin
        if (code == C_LK_GO) begin
          tmr_load = 1'b1;
          state_d  = S_LK_BUSY;
        end else if (leave) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= S_IDLE;
      err_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      sel_q   <= sel_d;
    end

  always_comb begin
    rdata_o = '0;
    case (state_q)
      S_PW_STAT: begin
        rdata_o[7] = 1'b1;
        rdata_o[5] = err_q;
      end
      S_VERIFY:  rdata_o = pw_lock ? '1 : part;
      S_LK_VER:  rdata_o[0] = sel_q ? ps_lock : pw_lock;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pwp_ctrl_chk.sv
module pwp_ctrl_chk
  import pwp_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic          busy_o,
  input logic [DW-1:0] rdata_o,
  input logic          pw_lock,
  input logic          ps_lock,
  input logic [PW-1:0] pwd,
  input state_e        state_q
);
  p_pw_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_lock |=> pw_lock);
  p_ps_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_lock |=> ps_lock);
  p_locks_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pw_lock && ps_lock));
  p_cells_only_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pwd & ~$past(pwd)) == '0));
  p_busy_write_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && we_i) |=> ($stable(pwd) && $stable(pw_lock) && $stable(ps_lock)));
  p_verify_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_VERIFY && pw_lock) |-> (rdata_o == '1));
  p_busy_no_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rdata_o == '0));
  p_locked_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pw_lock) |-> $stable(pwd));
endmodule

bind pwp_ctrl pwp_ctrl_chk #(.DW(DW), .PW(DW*4)) u_chk (
  .clk_i, .rst_ni, .we_i, .busy_o, .rdata_o,
  .pw_lock, .ps_lock, .pwd, .state_q
);

// File: tb/tb_pwp_ctrl.sv
module tb_pwp_ctrl;
  localparam int PC = 6;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic busy;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwp_ctrl #(.ADDR_W(12), .DW(16), .PROG_CYC(PC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: mode names as integers
  int m = 0, cnt = 0, sel = 0;
  bit err = 0, pwl = 0, psl = 0;
  logic [15:0] pw [4] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};

  function automatic logic [15:0] exp_rd();
    case (m)
      5:  return err ? 16'h00A0 : 16'h0080;
      6:  return pwl ? 16'hFFFF : pw[addr[1:0]];
      10: return {15'h0, (sel == 1) ? psl : pwl};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [7:0] c;
    c = wdata[7:0];
    if (!rst_n) begin
      m = 0; cnt = 0; sel = 0; err = 0; pwl = 0; psl = 0;
      foreach (pw[i]) pw[i] = 16'hFFFF;
    end else begin
      case (m)
        0: if (we && addr == 12'h555 && c == 8'hAA) m = 1;
        1: if (we) m = (addr == 12'h2AA && c == 8'h55) ? 2 : 0;
        2: if (we) begin
             m = 0;
             if (addr == 12'h555) begin
               if (c == 8'h38) m = 3;
               else if (c == 8'hC8) m = 6;
               else if (c == 8'h60) begin m = 7; sel = 0; end
               else if (c == 8'h64) begin m = 7; sel = 1; end
             end
           end
        3: if (we) begin
             err = pwl || ((wdata & ~pw[addr[1:0]]) != 0);
             if (!pwl) pw[addr[1:0]] = pw[addr[1:0]] & wdata;
             cnt = PC; m = 4;
           end
        4: begin cnt--; if (cnt == 0) m = 5; end
        5: if (we && c == 8'hF0) m = 0;
        6: if (we && (c == 8'hF0 || c == 8'h90)) m = 0;
        7: if (we) begin if (c == 8'h68) begin cnt = PC; m = 8; end else m = 0; end
        8: begin
             cnt--;
             if (cnt == 0) begin
               if (sel == 0 && !psl) pwl = 1;
               if (sel == 1 && !pwl) psl = 1;
               m = 9;
             end
           end
        9: if (we) m = (c == 8'h48) ? 10 : 0;
        10: if (we) begin
              if (c == 8'h68) begin cnt = PC; m = 8; end
              else if (c == 8'hF0 || c == 8'h90) m = 0;
            end
        default: m = 0;
      endcase
    end
    #2;
    if (!finished) begin
      chk("R6 model rdata", rdata, exp_rd());
      chk("R5 model busy", {15'h0, busy}, {15'h0, (m == 4 || m == 8)});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [15:0] e);
    addr = a;
    @(posedge clk); #2;
    chk(tag, rdata, e);
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic pw_prog(input logic [1:0] p, input logic [15:0] d);
    unlock(); wr(12'h555, 16'h0038); wr({10'h0, p}, d); wait_idle();
  endtask

  task automatic lock_prog(input logic [7:0] cmd);
    unlock(); wr(12'h555, {8'h0, cmd}); wr(12'h0, 16'h0068); wait_idle();
    wr(12'h0, 16'h0048);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    int n;
    do_reset();
    // R1
    rd("R1 reset rdata", 12'h0, 16'h0000);
    chk("R1 reset busy", {15'h0, busy}, 16'h0);
    unlock(); wr(12'h555, 16'h00C8);
    for (int i = 0; i < 4; i++) rd("R1 reset password", 12'(i), 16'hFFFF);
    wr(12'h0, 16'h00F0);

    // R3 R5 R10: program portion 2, writes during busy
    unlock(); wr(12'h555, 16'h0038); wr(12'h002, 16'h1234);
    chk("R5 busy start", {15'h0, busy}, 16'h1);
    wr(12'h002, 16'h0000);
    n = 1;
    while (busy) begin n++; @(negedge clk); end
    chk("R5 busy length", 16'(n), 16'(PC));
    rd("R5 status ok", 12'h0, 16'h0080);
    wr(12'h0, 16'h0055);
    rd("R5 status held", 12'h0, 16'h0080);
    wr(12'h0, 16'h00F0);
    rd("R5 after reset cmd", 12'h0, 16'h0000);
    unlock(); wr(12'h555, 16'h00C8);
    rd("R3 portion 2", 12'h002, 16'h1234);
    rd("R10 busy write ignored", 12'h002, 16'h1234);
    rd("R3 portion 0 untouched", 12'h000, 16'hFFFF);
    wr(12'h0, 16'h0090);
    rd("R6 exit 90h", 12'h002, 16'h0000);

    // R4
    pw_prog(2'd2, 16'h1334);
    rd("R4 error status", 12'h0, 16'h00A0);
    wr(12'h0, 16'h00F0);
    pw_prog(2'd0, 16'hA5A5);
    wr(12'h0, 16'h00F0);
    unlock(); wr(12'h555, 16'h00C8);
    rd("R4 cell stays 0", 12'h002, 16'h1234);
    rd("R3 portion 0", 12'h100, 16'hA5A5);
    wr(12'h0, 16'h00F0);

    // R2 wrong unlock data, wrong command address
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0056); wr(12'h555, 16'h00C8);
    rd("R2 bad unlock data", 12'h002, 16'h0000);
    unlock(); wr(12'h554, 16'h0038); wr(12'h002, 16'h0000);
    chk("R2 bad cmd address busy", {15'h0, busy}, 16'h0);
    // R11
    unlock(); wr(12'h555, 16'h0077); wr(12'h002, 16'h0000);
    chk("R11 unknown cmd busy", {15'h0, busy}, 16'h0);
    unlock(); wr(12'h555, 16'h00C8);
    rd("R2 R11 no change", 12'h002, 16'h1234);
    wr(12'h0, 16'h00F0);

    // R7 R12 persistent lock
    lock_prog(8'h64);
    rd("R7 persistent verify", 12'h0, 16'h0001);
    wr(12'h0, 16'h0068);
    chk("R12 rerun busy", {15'h0, busy}, 16'h1);
    wait_idle(); wr(12'h0, 16'h0048);
    rd("R12 rerun verify", 12'h0, 16'h0001);
    wr(12'h0, 16'h0090);
    rd("R12 exit", 12'h0, 16'h0000);
    // R8 password lock refused
    lock_prog(8'h60);
    rd("R8 pw lock refused", 12'h0, 16'h0000);
    wr(12'h0, 16'h00F0);
    // R7 wrong fourth code
    unlock(); wr(12'h555, 16'h0060); wr(12'h0, 16'h0012);
    chk("R7 bad fourth code busy", {15'h0, busy}, 16'h0);
    unlock(); wr(12'h555, 16'h00C8);
    rd("R8 verify still open", 12'h001, 16'hFFFF);
    wr(12'h0, 16'h00F0);

    // power-on reset, password lock path
    do_reset();
    unlock(); wr(12'h555, 16'h00C8);
    rd("R1 password back to ones", 12'h002, 16'hFFFF);
    wr(12'h0, 16'h00F0);
    pw_prog(2'd1, 16'h0F0F); wr(12'h0, 16'h00F0);
    lock_prog(8'h60);
    rd("R7 pw lock verify", 12'h0, 16'h0001);
    wr(12'h0, 16'h00F0);
    lock_prog(8'h64);
    rd("R8 persistent refused", 12'h0, 16'h0000);
    wr(12'h0, 16'h00F0);
    unlock(); wr(12'h555, 16'h00C8);
    rd("R6 verify blanked", 12'h001, 16'hFFFF);
    wr(12'h0, 16'h00F0);
    pw_prog(2'd1, 16'h0000);
    rd("R9 locked program error", 12'h0, 16'h00A0);
    wr(12'h0, 16'h00F0);
    lock_prog(8'h60);
    rd("R8 pw lock stays", 12'h0, 16'h0001);
    wr(12'h0, 16'h00F0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule